// File: doc/BRIEF.md
# Shift-Register Byte Transfer Engine

This block moves packets between a host and a packet-processing controller one byte at a time through an 8-bit shift-register register. The host writes two active-low control lines, in-progress and acknowledge, into a port data register, and sets a direction bit in an auxiliary control register. Each change of that line pair while in-progress is low is one transfer step. In the inbound direction a step hands the host the next byte of a pending reply. In the outbound direction a step captures the byte the host wrote into the shift register. The engine drives an active-low request line whenever reply bytes are waiting for the host.

Reply packets enter on a byte stream into a 128-byte buffer. Bus-device replies get a leading type byte of 0. When the host clears the direction bit, the outbound bytes collected so far, at most 16, are played out as one packet on an output byte stream. How the shift register is clocked on the wire is outside this block.

Host register map, selected by `reg_addr`:
- 0: port data. Bit 5 is in-progress and bit 4 is acknowledge, both active low. Bit 3 reads back the request line.
- 1: auxiliary control. Bit 4 is the direction, 1 meaning the host shifts out.
- 2: shift register.
- 3: flags. Bit 2 is the shift flag; writing 1 to it clears it.

Top module: `sr_xfer_engine`

## Requirements
- R1: After reset the request output `treq_n` is 1 and the shift flag is 0. A read of address 2 returns 0, and `out_valid` is 0. The port data register resets to 0x30, so both control lines are idle high, and the direction bit resets to 0.
- R2: A write to address 0 makes a transfer step only when its bit 5 is 0 and its bits {5,4} differ from those of the port data register before the write. Rewriting the same value, or any write with bit 5 set, makes no step.
- R3: With the direction bit at 0, a step while reply bytes are pending loads the next byte into the shift register, advances the read position and sets the shift flag. With the direction bit at 1, a step does not advance the reply.
- R4: `treq_n`, and bit 3 of the address 0 readback, are 0 while unread reply bytes remain and 1 once all of them have been consumed.
- R5: A read of address 2 returns the reply byte that the next step would hand over, or 0 when none remain.
- R6: With the direction bit at 1, a step copies the shift register, as last written at address 2, into the outbound buffer and sets the shift flag. Steps after the 16th byte of a packet are dropped.
- R7: A write to address 1 that takes the direction bit from 1 to 0 ends the outbound packet. The n collected bytes (n > 0) appear on `out_data` in order, on n consecutive cycles starting the cycle after the write, with `out_last` on the final byte. With n = 0 nothing is emitted, and a write that leaves the direction bit unchanged emits nothing.
- R8: The input stream stores one packet, accepting a byte on each cycle with `in_valid`. If `in_bus` is 1 on the first byte, a type byte 0 is stored ahead of the data; otherwise the bytes are stored as given. The byte with `in_last` completes the packet: the read position returns to the packet start and the shift flag is set.
- R9: Writing 1 to bit 2 of address 3 clears the shift flag. A flag-setting event in the same cycle wins over the clear.
- R10: Reply bytes beyond 128 in one packet are dropped. The packet then holds its first 128 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 2 | Host register select |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data for `reg_addr` |
| treq_n | output | 1 | Active-low request: reply bytes pending |
| sr_flag | output | 1 | Shift flag |
| in_valid | input | 1 | Reply byte valid |
| in_bus | input | 1 | Reply is a bus-device packet (sampled on first byte) |
| in_last | input | 1 | Final byte of reply packet |
| in_data | input | 8 | Reply byte |
| out_valid | output | 1 | Outbound packet byte valid |
| out_last | output | 1 | Final byte of outbound packet |
| out_data | output | 8 | Outbound packet byte |

## Verification
The step rule is driven three ways: with the acknowledge line toggling while in-progress stays low, with the same value written twice, and with in-progress raised. Together these separate a detector that watches changes from one that watches levels, and from one that ignores the in-progress gate. Reply traffic covers a controller packet, a bus packet that gains a type prefix, and a 130-byte packet. These tell apart prefix placement, read-position reset and the buffer cap. Outbound packets of two bytes, eighteen bytes and zero bytes are checked through a scoreboard of expected bytes and last markers. These show order, truncation at 16, and that an empty packet produces nothing.

// File: rtl/sr_xfer_pkg.sv
package sr_xfer_pkg;
  localparam int BYTE_W = 8;
  localparam int RADDR_W = 2;

  localparam logic [RADDR_W-1:0] A_PORT  = 2'd0;
  localparam logic [RADDR_W-1:0] A_AUX   = 2'd1;
  localparam logic [RADDR_W-1:0] A_SHIFT = 2'd2;
  localparam logic [RADDR_W-1:0] A_FLAG  = 2'd3;

  localparam int BIT_REQ = 3;
  localparam int BIT_ACK = 4;
  localparam int BIT_TIP = 5;
  localparam int BIT_DIR = 4;
  localparam int BIT_SRF = 2;

  localparam logic [BYTE_W-1:0] PORT_RST = 8'h30;

  // line pair is {in_progress, acknowledge}, both active low
  function automatic logic step_due(input logic [1:0] old_pair,
                                    input logic [1:0] new_pair);
    return (new_pair[1] == 1'b0) && (new_pair != old_pair);
  endfunction

  function automatic logic dir_fell(input logic old_dir, input logic new_dir);
    return old_dir && !new_dir;
  endfunction
endpackage

// File: rtl/sr_handshake.sv
module sr_handshake
  import sr_xfer_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [RADDR_W-1:0]  addr,
  input  logic [BYTE_W-1:0]   wdata,
  output logic [BYTE_W-1:0]   port_q,
  output logic [BYTE_W-1:0]   aux_q,
  output logic                dir,
  output logic                step,
  output logic                pkt_end
);
  logic port_wr, aux_wr;

  assign port_wr = wr_en && (addr == A_PORT);
  assign aux_wr  = wr_en && (addr == A_AUX);
  assign dir     = aux_q[BIT_DIR];

  assign step    = port_wr && step_due({port_q[BIT_TIP], port_q[BIT_ACK]},
                                       {wdata[BIT_TIP], wdata[BIT_ACK]});
  assign pkt_end = aux_wr && dir_fell(aux_q[BIT_DIR], wdata[BIT_DIR]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q <= PORT_RST;
      aux_q  <= '0;
    end else begin
      if (port_wr) port_q <= wdata;
      if (aux_wr)  aux_q  <= wdata;
    end
  end

  assert_step_tip_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> !port_q[BIT_TIP]);
  assert_repeat_no_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr && wdata[BIT_TIP:BIT_ACK] == port_q[BIT_TIP:BIT_ACK]) |-> !step);
  assert_end_dir_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |=> !dir);
endmodule

// File: rtl/sr_inbound_buf.sv
module sr_inbound_buf
  import sr_xfer_pkg::*;
#(
  parameter int DEPTH = 128
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_bus,
  input  logic              in_last,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              step_en,
  output logic              pending,
  output logic              advance,
  output logic              commit,
  output logic [BYTE_W-1:0] pend_byte
);
  localparam int AW    = $clog2(DEPTH);
  localparam int IDX_W = AW + 2;
  localparam logic [IDX_W-1:0] DEPTH_V = IDX_W'(DEPTH);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic              filling;
  logic [IDX_W-1:0]  wptr, len, rd;
  logic              prefix;
  logic [IDX_W-1:0]  base, data_pos, nxt, nxt_cap;

  assign prefix   = !filling && in_bus;
  assign base     = filling ? wptr : '0;
  assign data_pos = base + (prefix ? IDX_W'(1) : IDX_W'(0));
  assign nxt      = data_pos + IDX_W'(1);
  assign nxt_cap  = (nxt > DEPTH_V) ? DEPTH_V : nxt;

  assign pending   = rd < len;
  assign advance   = step_en && pending;
  assign commit    = in_valid && in_last;
  assign pend_byte = pending ? mem[rd[AW-1:0]] : '0;

  always_ff @(posedge clk) begin
    if (in_valid) begin
      if (prefix) mem[0] <= '0;
      if (data_pos < DEPTH_V) mem[data_pos[AW-1:0]] <= in_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filling <= 1'b0;
      wptr    <= '0;
      len     <= '0;
      rd      <= '0;
    end else begin
      if (in_valid) begin
        wptr    <= nxt_cap;
        filling <= !in_last;
      end
      if (commit) begin
        len <= nxt_cap;
        rd  <= '0;
      end else if (advance) begin
        rd  <= rd + IDX_W'(1);
      end
    end
  end

  assert_commit_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> pending);
  assert_advance_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !commit) |=> rd == $past(rd) + IDX_W'(1));
  assert_len_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    len <= DEPTH_V);
endmodule

// File: rtl/sr_outbound_buf.sv
module sr_outbound_buf
  import sr_xfer_pkg::*;
#(
  parameter int DEPTH = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [BYTE_W-1:0] sr_byte,
  input  logic              pkt_end,
  output logic              out_valid,
  output logic              out_last,
  output logic [BYTE_W-1:0] out_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] DEPTH_V = CW'(DEPTH);

  logic [BYTE_W-1:0] obuf [DEPTH];
  logic [CW-1:0]     cnt, emit_len, emit_idx;
  logic              emitting, take;

  assign take      = step_en && (cnt < DEPTH_V);
  assign out_valid = emitting;
  assign out_last  = emitting && (emit_idx == emit_len - CW'(1));
  assign out_data  = emitting ? obuf[emit_idx[AW-1:0]] : '0;

  always_ff @(posedge clk) begin
    if (take) obuf[cnt[AW-1:0]] <= sr_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      emit_len <= '0;
      emit_idx <= '0;
      emitting <= 1'b0;
    end else begin
      if (pkt_end) begin
        cnt <= '0;
        if (cnt != '0) begin
          emitting <= 1'b1;
          emit_len <= cnt;
          emit_idx <= '0;
        end
      end else begin
        if (take) cnt <= cnt + CW'(1);
        if (emitting) begin
          if (out_last) emitting <= 1'b0;
          else          emit_idx <= emit_idx + CW'(1);
        end
      end
    end
  end

  assert_cnt_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= DEPTH_V);
  assert_emit_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_end && cnt != '0) |=> out_valid);
  assert_empty_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_end && cnt == '0 && !out_valid) |=> !out_valid);
  assert_last_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_last && !pkt_end) |=> !out_valid);
endmodule

// File: rtl/sr_xfer_engine.sv
module sr_xfer_engine
  import sr_xfer_pkg::*;
#(
  parameter int IN_DEPTH  = 128,
  parameter int OUT_DEPTH = 16
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [RADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0]  reg_wdata,
  output logic [BYTE_W-1:0]  reg_rdata,
  output logic               treq_n,
  output logic               sr_flag,
  input  logic               in_valid,
  input  logic               in_bus,
  input  logic               in_last,
  input  logic [BYTE_W-1:0]  in_data,
  output logic               out_valid,
  output logic               out_last,
  output logic [BYTE_W-1:0]  out_data
);
  localparam logic [BYTE_W-1:0] REQ_MASK = BYTE_W'(1) << BIT_REQ;

  logic [BYTE_W-1:0] port_q, aux_q, shift_q, pend_byte;
  logic dir, step, pkt_end, pending, advance, commit;
  logic in_step, out_step, flag_set, flag_clr;

  sr_handshake u_hs (
    .clk, .rst_n, .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .port_q, .aux_q, .dir, .step, .pkt_end
  );

  assign in_step  = step && !dir;
  assign out_step = step && dir;

  sr_inbound_buf #(.DEPTH(IN_DEPTH)) u_in (
    .clk, .rst_n, .in_valid, .in_bus, .in_last, .in_data,
    .step_en(in_step), .pending, .advance, .commit, .pend_byte
  );

  sr_outbound_buf #(.DEPTH(OUT_DEPTH)) u_out (
    .clk, .rst_n, .step_en(out_step), .sr_byte(shift_q), .pkt_end,
    .out_valid, .out_last, .out_data
  );

  assign flag_set = advance || out_step || commit;
  assign flag_clr = reg_wr && (reg_addr == A_FLAG) && reg_wdata[BIT_SRF];
  assign treq_n   = !pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      sr_flag <= 1'b0;
    end else begin
      if (advance)                                  shift_q <= pend_byte;
      else if (reg_wr && reg_addr == A_SHIFT)       shift_q <= reg_wdata;
      if (flag_set)      sr_flag <= 1'b1;
      else if (flag_clr) sr_flag <= 1'b0;
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_PORT:  reg_rdata = (port_q & ~REQ_MASK) | (treq_n ? REQ_MASK : '0);
      A_AUX:   reg_rdata = aux_q;
      A_SHIFT: reg_rdata = pend_byte;
      default: reg_rdata = sr_flag ? (BYTE_W'(1) << BIT_SRF) : '0;
    endcase
  end

  assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |=> sr_flag);
  assert_commit_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !treq_n);
  assert_out_dir_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_step && !commit) |=> $stable(pend_byte));
endmodule

// File: tb/sr_xfer_engine_tb.sv
`timescale 1ns/1ps
module sr_xfer_engine_tb;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic treq_n, sr_flag;
  logic in_valid = 0, in_bus = 0, in_last = 0;
  logic [7:0] in_data = 0;
  logic out_valid, out_last;
  logic [7:0] out_data;

  int n_tests = 0, n_fail = 0, n_emit = 0;
  logic [8:0] expq [$];          // {last, data}
  logic [7:0] pb = 8'h30;
  logic [7:0] v;

  always #10 clk = ~clk;

  sr_xfer_engine u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    if (a == 2'd0) pb = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  // toggle acknowledge with in-progress held low
  task automatic step();
    wr(2'd0, pb[4] ? 8'h00 : 8'h10);
  endtask

  task automatic send(input logic bus, input logic [7:0] d, input logic last);
    @(negedge clk); in_valid = 1; in_bus = bus; in_data = d; in_last = last;
    @(negedge clk); in_valid = 0; in_last = 0;
  endtask

  // scoreboard monitor
  always @(negedge clk) if (rst_n && out_valid) begin
    n_emit++;
    if (expq.size() == 0) chk("R7 unexpected byte", {out_last, out_data}, 9'h1ff);
    else chk("R7 out byte", {out_last, out_data}, expq.pop_front());
  end

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk); rst_n = 1;
    // R1 reset state
    chk("R1 treq_n", treq_n, 1); chk("R1 flag", sr_flag, 0);
    chk("R1 out_valid", out_valid, 0);
    rd(2'd2, v); chk("R1 shift read", v, 0);
    rd(2'd0, v); chk("R1 port read", v, 8'h38);

    // R8 controller reply, no prefix
    send(0, 8'h01, 0); send(0, 8'h22, 0); send(0, 8'h33, 1);
    chk("R8 flag after load", sr_flag, 1); chk("R4 treq low", treq_n, 0);
    rd(2'd2, v); chk("R5 first pending", v, 8'h01);
    rd(2'd0, v); chk("R4 port bit3 low", v[3], 0);
    wr(2'd3, 8'h04); chk("R9 flag cleared", sr_flag, 0);

    // R2/R3 steps
    wr(2'd0, 8'h10); rd(2'd2, v); chk("R3 advanced", v, 8'h22);
    chk("R3 flag set", sr_flag, 1);
    wr(2'd0, 8'h10); rd(2'd2, v); chk("R2 repeat no step", v, 8'h22);
    wr(2'd0, 8'h20); rd(2'd2, v); chk("R2 tip high no step", v, 8'h22);
    wr(2'd0, 8'h00); rd(2'd2, v); chk("R3 second step", v, 8'h33);
    step(); rd(2'd2, v); chk("R5 none left", v, 0);
    chk("R4 treq high", treq_n, 1);
    rd(2'd0, v); chk("R4 port bit3 high", v[3], 1);

    // R8 bus reply gets type 0 prefix
    send(1, 8'h40, 0); send(1, 8'h2c, 1);
    rd(2'd2, v); chk("R8 type prefix", v, 0);
    step(); rd(2'd2, v); chk("R8 first data", v, 8'h40);

    // R6/R7 outbound two bytes; R3 inbound frozen in dir=1
    wr(2'd1, 8'h10);
    wr(2'd2, 8'ha5); step(); chk("R6 flag", sr_flag, 1);
    wr(2'd2, 8'h5a); step();
    rd(2'd2, v); chk("R3 no advance in dir 1", v, 8'h40);
    expq.push_back({1'b0, 8'ha5}); expq.push_back({1'b1, 8'h5a});
    wr(2'd1, 8'h00);
    repeat (8) @(negedge clk);
    chk("R7 two bytes drained", expq.size(), 0);

    // R6 truncation at 16
    wr(2'd1, 8'h10);
    for (int i = 0; i < 18; i++) begin
      wr(2'd2, 8'(i + 8'h80)); step();
      if (i < 16) expq.push_back({i == 15, 8'(i + 8'h80)});
    end
    wr(2'd1, 8'h00);
    repeat (24) @(negedge clk);
    chk("R6 sixteen drained", expq.size(), 0);

    // R7 empty packet and unchanged direction
    n_emit = 0;
    wr(2'd1, 8'h10); wr(2'd1, 8'h10); wr(2'd1, 8'h00); wr(2'd1, 8'h00);
    repeat (4) @(negedge clk);
    chk("R7 empty emits nothing", n_emit, 0);

    // R9 set wins over clear
    wr(2'd3, 8'h04);
    fork
      send(0, 8'h77, 1);
      wr(2'd3, 8'h04);
    join
    chk("R9 set beats clear", sr_flag, 1);

    // R10 long packet capped at 128
    for (int i = 0; i < 130; i++) send(0, 8'(i), i == 129);
    for (int i = 0; i < 127; i++) step();
    rd(2'd2, v); chk("R10 byte 127", v, 8'd127);
    chk("R10 treq still low", treq_n, 0);
    step(); rd(2'd2, v); chk("R10 dropped tail", v, 0);
    chk("R10 treq high", treq_n, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule